// File: doc/BRIEF.md
# Fan PWM Duty Generator

This block drives one fan output line with a pulse-width modulated waveform. Each PWM period is 64 ticks long. A 6-bit duty value sets how many of those ticks the output spends high, which gives steps of about 1.56%. The output is high for duty/64 of each period. A force bit in the same register holds the output high at any duty setting.

The tick comes from the system clock through an enable-pulse divider. The divider has four base ratios. The per-fan clock-select bit and the source-select bit of a control byte pick one of them. A doubling bit in the control byte halves the selected ratio, which doubles the tick rate. A new duty value is held in a shadow copy and only takes effect at the next period boundary, so a write never produces a runt pulse.

Top module: `fan_pwm`

## Requirements
- R1: After reset is asserted, `fan_o` is low, and the duty value and the force bit are both zero.
- R2: In a write to `fan_wdata_i` (strobed by `fan_we_i`), bit 7 is the clock-select bit, bits 6:1 are the duty value and bit 0 is the force bit.
- R3: When the force bit is clear, each period of 64 ticks has exactly `duty` high ticks, so the output is high for `duty * div` of every `64 * div` clocks. A duty value of 0 keeps the output low throughout.
- R4: A duty value of 63 gives 63 high ticks and 1 low tick in every period. The output never stays high for a whole period.
- R5: When the force bit is set, `fan_o` is high on the second clock edge after the write and stays high for any duty value. Clearing the force bit returns control to the duty value.
- R6: A duty value written partway through a period does not change the output before the next period boundary. After that boundary it applies to every later period.
- R7: The base divide ratio is indexed by {clock-select, source-select}: 00 selects `DIV_0`, 01 selects `DIV_1`, 10 selects `DIV_2` and 11 selects `DIV_3` system clocks per tick.
- R8: In a write to `ctl_wdata_i` (strobed by `ctl_we_i`), bit 0 is the source-select bit and bit 1 is the doubling bit. When the doubling bit is 1, the tick period is half of the selected base ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fan_we_i | input | 1 | Write strobe for the per-fan register |
| fan_wdata_i | input | 8 | Per-fan register data: clock-select, duty, force |
| ctl_we_i | input | 1 | Write strobe for the control bits |
| ctl_wdata_i | input | 2 | Control data: doubling bit (bit 1), source-select bit (bit 0) |
| fan_o | output | 1 | PWM fan drive output |

## Verification
The assertions make three assumptions about the inputs:
- Every write is a single-cycle strobe.
- Every divide parameter is even and at least 4, so every tick gap falls between one clock and the largest base ratio.
- The shadow duty value changes only on the tick that wraps the phase counter from 63.

The bench drives each write for exactly one clock, away from the active edge, and uses only the default even ratios. It changes the ratio and the duty value at arbitrary phases and then lets several full periods pass. Only after that does it count high clocks over exactly one period, so the count does not depend on where in the period the count starts.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int unsigned PHASE_W = 6;
  localparam logic [PHASE_W-1:0] PHASE_LAST = '1;

  typedef struct packed {
    logic               clk_sel;
    logic [PHASE_W-1:0] duty;
    logic               force_hi;
  } fan_reg_t;

  typedef struct packed {
    logic dbl;
    logic src_sel;
  } fan_ctl_t;
endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
  import fan_pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fan_we_i,
  input  logic [7:0] fan_wdata_i,
  input  logic       ctl_we_i,
  input  logic [1:0] ctl_wdata_i,
  output fan_reg_t   fan_q_o,
  output fan_ctl_t   ctl_q_o
);
  fan_reg_t fan_q;
  fan_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fan_q <= '0;
      ctl_q <= '0;
    end else begin
      if (fan_we_i) fan_q <= fan_reg_t'(fan_wdata_i);
      if (ctl_we_i) ctl_q <= fan_ctl_t'(ctl_wdata_i);
    end
  end

  assign fan_q_o = fan_q;
  assign ctl_q_o = ctl_q;
endmodule

// File: rtl/fan_pwm_tick.sv
module fan_pwm_tick #(
  parameter int unsigned DIV_0 = 4,
  parameter int unsigned DIV_1 = 6,
  parameter int unsigned DIV_2 = 8,
  parameter int unsigned DIV_3 = 12,
  parameter int unsigned MAX_DIV = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       dbl_i,
  output logic       tick_o
);
  localparam int unsigned CW = $clog2(MAX_DIV + 1);
  localparam int unsigned N_RATIO = 4;

  logic [CW-1:0] ratio [N_RATIO];

  // one divide ratio per selector code
  for (genvar g = 0; g < int'(N_RATIO); g++) begin : g_ratio
    localparam int unsigned RV = (g == 0) ? DIV_0 :
                                 (g == 1) ? DIV_1 :
                                 (g == 2) ? DIV_2 : DIV_3;
    assign ratio[g] = CW'(RV);
  end

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          tc;

  always_comb begin
    lim = ratio[sel_i];
    if (dbl_i) lim = lim >> 1;
  end

  // >= guards against a ratio change that leaves cnt_q past the new limit
  assign tc = (cnt_q >= (lim - CW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (tc)  cnt_q <= '0;
    else          cnt_q <= cnt_q + CW'(1);
  end

  assign tick_o = tc;
endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core
  import fan_pwm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [PHASE_W-1:0] duty_i,
  input  logic               force_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [PHASE_W-1:0] duty_act_o,
  output logic               pwm_o
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] duty_act_q;
  logic               pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= '0;
      duty_act_q <= '0;
      pwm_q      <= 1'b0;
    end else begin
      if (tick_i) begin
        phase_q <= phase_q + PHASE_W'(1);
        if (phase_q == PHASE_LAST) duty_act_q <= duty_i;
      end
      pwm_q <= force_i | (phase_q < duty_act_q);
    end
  end

  assign phase_o    = phase_q;
  assign duty_act_o = duty_act_q;
  assign pwm_o      = pwm_q;
endmodule

// File: rtl/fan_pwm.sv
module fan_pwm
  import fan_pwm_pkg::*;
#(
  parameter int unsigned DIV_0 = 4,
  parameter int unsigned DIV_1 = 6,
  parameter int unsigned DIV_2 = 8,
  parameter int unsigned DIV_3 = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fan_we_i,
  input  logic [7:0] fan_wdata_i,
  input  logic       ctl_we_i,
  input  logic [1:0] ctl_wdata_i,
  output logic       fan_o
);
  localparam int unsigned MAX_A   = (DIV_0 > DIV_1) ? DIV_0 : DIV_1;
  localparam int unsigned MAX_B   = (DIV_2 > DIV_3) ? DIV_2 : DIV_3;
  localparam int unsigned MAX_DIV = (MAX_A > MAX_B) ? MAX_A : MAX_B;

  fan_reg_t           fan_q;
  fan_ctl_t           ctl_q;
  logic               tick;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] duty_act;

  fan_pwm_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fan_we_i   (fan_we_i),
    .fan_wdata_i(fan_wdata_i),
    .ctl_we_i   (ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i),
    .fan_q_o    (fan_q),
    .ctl_q_o    (ctl_q)
  );

  fan_pwm_tick #(
    .DIV_0  (DIV_0),
    .DIV_1  (DIV_1),
    .DIV_2  (DIV_2),
    .DIV_3  (DIV_3),
    .MAX_DIV(MAX_DIV)
  ) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i ({fan_q.clk_sel, ctl_q.src_sel}),
    .dbl_i (ctl_q.dbl),
    .tick_o(tick)
  );

  fan_pwm_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .duty_i    (fan_q.duty),
    .force_i   (fan_q.force_hi),
    .phase_o   (phase),
    .duty_act_o(duty_act),
    .pwm_o     (fan_o)
  );
endmodule

// File: rtl/fan_pwm_chk.sv
module fan_pwm_chk #(
  parameter int unsigned MAX_DIV = 12
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [5:0] phase_i,
  input logic [5:0] duty_act_i,
  input logic       force_i,
  input logic       fan_o
);
  logic [15:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= '0;
    else if (tick_i) gap_q <= '0;
    else             gap_q <= gap_q + 16'd1;
  end

  // R7: ticks never further apart than the largest base ratio
  assert_tick_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q < 16'(MAX_DIV));

  // R3: phase moves by one per tick and holds otherwise
  assert_phase_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> phase_i == 6'($past(phase_i) + 6'd1));
  assert_phase_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_i));

  // R6: the duty in use changes only on the wrapping tick
  assert_duty_at_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_act_i != $past(duty_act_i)) |-> $past(tick_i && phase_i == 6'd63));

  // R5: force holds the output high
  assert_force_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> fan_o);

  // R3: zero duty without force keeps the output low
  assert_zero_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && duty_act_i == 6'd0) |=> !fan_o);
endmodule

bind fan_pwm fan_pwm_chk #(.MAX_DIV(MAX_DIV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick),
  .phase_i   (phase),
  .duty_act_i(duty_act),
  .force_i   (fan_q.force_hi),
  .fan_o     (fan_o)
);

// File: tb/sim_fan_pwm.sv
`timescale 1ns/1ps
module sim_fan_pwm;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fan_we_i = 1'b0;
  logic [7:0] fan_wdata_i = '0;
  logic       ctl_we_i = 1'b0;
  logic [1:0] ctl_wdata_i = '0;
  logic       fan_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk_i = ~clk_i;

  fan_pwm u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fan_we_i   (fan_we_i),
    .fan_wdata_i(fan_wdata_i),
    .ctl_we_i   (ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i),
    .fan_o      (fan_o)
  );

  function automatic int eff_div(bit cs, bit src, bit dbl);
    int b;
    case ({cs, src})
      2'b00: b = 4;
      2'b01: b = 6;
      2'b10: b = 8;
      default: b = 12;
    endcase
    return dbl ? b / 2 : b;
  endfunction

  function automatic int exp_high(int duty, bit frc, int d);
    return frc ? 64 * d : duty * d;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_fan(bit cs, int duty, bit frc);
    @(negedge clk_i);
    fan_we_i = 1'b1;
    fan_wdata_i = {cs, 6'(duty), frc};
    @(negedge clk_i);
    fan_we_i = 1'b0;
  endtask

  task automatic wr_ctl(bit dbl, bit src);
    @(negedge clk_i);
    ctl_we_i = 1'b1;
    ctl_wdata_i = {dbl, src};
    @(negedge clk_i);
    ctl_we_i = 1'b0;
  endtask

  task automatic count_high(int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (fan_o) hi++;
    end
  endtask

  task automatic run_case(string req, bit cs, bit src, bit dbl, int duty, bit frc);
    int d;
    int hi;
    d = eff_div(cs, src, dbl);
    wr_ctl(dbl, src);
    wr_fan(cs, duty, frc);
    repeat (3 * 64 * 12) @(negedge clk_i);
    count_high(64 * d, hi);
    check(req, hi, exp_high(duty, frc, d));
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int hi;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: idle after reset
    check("R1 reset output", int'(fan_o), 0);
    count_high(64 * 4 * 2, hi);
    check("R1 reset duty zero", hi, 0);

    // R3 / R7 / R2: each base ratio with a mid duty value
    run_case("R3 R7 ratio00", 0, 0, 0, 20, 0);
    run_case("R7 ratio01",    0, 1, 0, 33, 0);
    run_case("R7 ratio10 R2", 1, 0, 0, 10, 0);
    run_case("R7 ratio11",    1, 1, 0, 50, 0);
    // R8: doubling halves the ratio
    run_case("R8 double 11",  1, 1, 1, 50, 0);
    run_case("R8 double 01",  0, 1, 1, 7, 0);
    // R3 zero / R4 full scale
    run_case("R3 duty zero",  1, 0, 0, 0, 0);
    run_case("R4 duty 63",    1, 1, 0, 63, 0);
    run_case("R4 duty 63 fast", 0, 0, 1, 63, 0);
    // R5: force at zero duty and at mid duty
    run_case("R5 force duty0",  0, 1, 0, 0, 1);
    run_case("R5 force duty40", 1, 0, 1, 40, 1);

    // R5: force latency of two edges from idle low output
    wr_ctl(0, 0);
    wr_fan(0, 0, 0);
    repeat (2 * 64 * 4) @(negedge clk_i);
    fan_we_i = 1'b1;
    fan_wdata_i = 8'b0000_0001;
    @(negedge clk_i);
    fan_we_i = 1'b0;
    check("R5 not yet high", int'(fan_o), 0);
    @(negedge clk_i);
    check("R5 high after second edge", int'(fan_o), 1);
    // R5: release returns to duty control
    run_case("R5 release", 0, 0, 0, 16, 0);

    // R6: mid-period write has no effect before the boundary
    begin
      int d;
      int lo_hi;
      d = eff_div(1, 0, 0);
      run_case("R6 setup", 1, 0, 0, 32, 0);
      do @(negedge clk_i); while (fan_o);
      do @(negedge clk_i); while (!fan_o);
      repeat (40 * d) @(negedge clk_i);
      wr_fan(1, 63, 0);
      count_high(16 * d, lo_hi);
      check("R6 no change before boundary", lo_hi, 0);
      repeat (2 * 64 * d) @(negedge clk_i);
      count_high(64 * d, lo_hi);
      check("R6 applied after boundary", lo_hi, 63 * d);
    end

    // random mix
    for (int k = 0; k < 14; k++) begin
      bit cs  = 1'($urandom);
      bit src = 1'($urandom);
      bit dbl = 1'($urandom);
      int dt  = int'($urandom % 64);
      bit frc = (($urandom % 8) == 0);
      run_case(frc ? "R5 random" : "R3 R7 R8 random", cs, src, dbl, dt, frc);
    end

    // R1: reset mid-run clears everything
    wr_fan(1, 45, 1);
    repeat (10) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 reset clears output", int'(fan_o), 0);
    rst_ni = 1'b1;
    count_high(64 * 4 * 2, hi);
    check("R1 reset clears duty and force", hi, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule